// File: doc/BRIEF.md
# Make-Before-Break Wiper Tap Decoder

This block turns a 7-bit wiper code into 128 tap-select enables, one per tap of a resistor string. The string has 127 resistive elements, so it has 128 taps. Enable bit 0 closes the switch at the tap nearest the low terminal. Enable bit 127 closes the switch at the tap nearest the high terminal. A larger code moves the selected tap monotonically toward the high end.

When the code changes, the wiper must never be left without a closed switch. The block therefore first closes the switch of the newly requested tap. It holds both the old and the new switch closed for a set number of overlap cycles, and only then opens the old one. During that overlap the busy flag is high.

A code that changes again during an overlap is not acted on immediately. The running transition finishes, the block settles for one cycle on the tap it reached, and then it starts a new transition toward the latest code. The overlap length is a parameter (default 2 cycles). At a 200 MHz clock the whole move takes far less than the one-microsecond budget a wiper update is allowed.

The sequencer is a two-state machine:
- STEADY: one tap is closed.
- OVERLAP: the old tap and the new tap are both closed.

It has three transitions:
- START_MOVE: STEADY to OVERLAP, taken when the sampled code differs from the current tap.
- FINISH_MOVE: OVERLAP to STEADY, taken when the overlap timer expires. At this point the new tap becomes the current tap.
- HOLD: the machine stays in its present state, taken in every other case.

Top module: `mbb_wiper_tap_decoder`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, exactly enable bit 64 is high and busy is 0.
- R2: In STEADY, the enables equal a single 1 at bit position equal to the current code. Bit 0 is the low-terminal tap and bit 127 is the high-terminal tap.
- R3: When the code sampled at a rising edge differs from the current tap, the next cycle starts an overlap. For exactly OVERLAP_CYC cycles, busy is 1 and exactly two enables are high: the old tap and the new tap.
- R4: In the cycle after the last overlap cycle, busy is 0 and only the new tap's enable is high.
- R5: A code equal to the current tap starts no transition. Busy stays 0 and the enables do not change.
- R6: Code changes during an overlap do not alter it. After the overlap, one STEADY cycle on the reached tap follows. Then a new overlap begins from that tap toward the latest code.
- R7: Moves between the extreme codes 0 and 127, in both directions, follow R3 and R4.
- R8: After reset, the enables are never all zero. An enable falls only at the end of an overlap, and never in the same cycle in which another enable rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| code_in | input | 7 | Requested wiper code |
| tap_en | output | 128 | Tap switch enables, bit i closes tap i |
| busy | output | 1 | High during an overlap |

## Verification
The two functions that can fall in the same cycle are the completion of a running overlap and the arrival of a new code. The bench changes the code in the first cycle of an overlap, then holds it. It checks that the first overlap still runs its full length with the original pair of taps, that a single STEADY cycle on the intermediate tap follows, and that a second overlap then starts from that tap toward the late code. A variant returns the code to the starting tap during the overlap, and the bench expects a full move back.

// File: rtl/mbb_pkg.sv
package mbb_pkg;
    typedef enum logic {
        SEQ_STEADY  = 1'b0,
        SEQ_OVERLAP = 1'b1
    } seq_state_e;
endpackage

// File: rtl/mbb_tap_onehot.sv
module mbb_tap_onehot #(
    parameter int CODE_W = 7,
    parameter int TAPS   = 1 << CODE_W
) (
    input  logic [CODE_W-1:0] code,
    input  logic              valid,
    output logic [TAPS-1:0]   en
);
    // One comparator per tap; all zero when not valid.
    for (genvar i = 0; i < TAPS; i++) begin : g_tap
        assign en[i] = valid && (code == CODE_W'(i));
    end
endmodule

// File: rtl/mbb_overlap_timer.sv
module mbb_overlap_timer #(
    parameter int OVERLAP_CYC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic done
);
    localparam int CNT_W = (OVERLAP_CYC > 1) ? $clog2(OVERLAP_CYC) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(OVERLAP_CYC - 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
        end else if (cnt != LAST) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign done = run && (cnt == LAST);

    // R3: the counter never passes the overlap length
    AST_TIMER_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST);  // R3
    // R3: the counter is cleared whenever no overlap is running
    AST_TIMER_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (cnt == '0));  // R3
endmodule

// File: rtl/mbb_tap_sequencer.sv
module mbb_tap_sequencer
    import mbb_pkg::*;
#(
    parameter int CODE_W     = 7,
    parameter int RESET_CODE = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] code_in,
    input  logic              timer_done,
    output logic [CODE_W-1:0] cur_code,
    output logic [CODE_W-1:0] nxt_code,
    output logic              overlapping,
    output logic              timer_run
);
    seq_state_e        state, state_nx;
    logic [CODE_W-1:0] cur_q, cur_nx, nxt_q, nxt_nx;

    // State register process
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= SEQ_STEADY;
            cur_q <= CODE_W'(RESET_CODE);
            nxt_q <= CODE_W'(RESET_CODE);
        end else begin
            state <= state_nx;
            cur_q <= cur_nx;
            nxt_q <= nxt_nx;
        end
    end

    // Next-state logic: START_MOVE, FINISH_MOVE, HOLD
    always_comb begin
        state_nx = state;
        cur_nx   = cur_q;
        nxt_nx   = nxt_q;
        unique case (state)
            SEQ_STEADY: begin
                if (code_in != cur_q) begin
                    nxt_nx   = code_in;
                    state_nx = SEQ_OVERLAP;
                end
            end
            SEQ_OVERLAP: begin
                if (timer_done) begin
                    cur_nx   = nxt_q;
                    state_nx = SEQ_STEADY;
                end
            end
        endcase
    end

    // Output process
    always_comb begin
        cur_code    = cur_q;
        nxt_code    = nxt_q;
        overlapping = 1'b0;
        timer_run   = 1'b0;
        unique case (state)
            SEQ_STEADY:  ;
            SEQ_OVERLAP: begin
                overlapping = 1'b1;
                timer_run   = 1'b1;
            end
        endcase
    end

    // R3: an overlap always pairs two distinct taps
    AST_OVERLAP_DISTINCT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SEQ_OVERLAP) |-> (nxt_q != cur_q));  // R3
    // R6: the target of a running overlap does not move
    AST_TARGET_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SEQ_OVERLAP) && $past(state == SEQ_OVERLAP) |-> $stable(nxt_q));  // R6
    // R6: after an overlap, one STEADY cycle always follows
    AST_SETTLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(state == SEQ_OVERLAP) |=> (state == SEQ_STEADY) || $past(code_in != nxt_q));  // R6
endmodule

// File: rtl/mbb_wiper_tap_decoder.sv
module mbb_wiper_tap_decoder #(
    parameter int CODE_W      = 7,
    parameter int OVERLAP_CYC = 2,
    parameter int RESET_CODE  = 64,
    localparam int TAPS       = 1 << CODE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] code_in,
    output logic [TAPS-1:0]   tap_en,
    output logic              busy
);
    logic [CODE_W-1:0] cur_code, nxt_code;
    logic              overlapping, timer_run, timer_done;
    logic [TAPS-1:0]   en_old, en_new;

    mbb_tap_sequencer #(
        .CODE_W     (CODE_W),
        .RESET_CODE (RESET_CODE)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .code_in     (code_in),
        .timer_done  (timer_done),
        .cur_code    (cur_code),
        .nxt_code    (nxt_code),
        .overlapping (overlapping),
        .timer_run   (timer_run)
    );

    mbb_overlap_timer #(
        .OVERLAP_CYC (OVERLAP_CYC)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (timer_run),
        .done  (timer_done)
    );

    mbb_tap_onehot #(.CODE_W(CODE_W), .TAPS(TAPS)) u_dec_old (
        .code  (cur_code),
        .valid (1'b1),
        .en    (en_old)
    );

    mbb_tap_onehot #(.CODE_W(CODE_W), .TAPS(TAPS)) u_dec_new (
        .code  (nxt_code),
        .valid (overlapping),
        .en    (en_new)
    );

    assign tap_en = en_old | en_new;
    assign busy   = overlapping;

    // R2: outside an overlap exactly one tap is closed
    AST_SINGLE_TAP: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> ($countones(tap_en) == 1));  // R2
    // R3: during an overlap exactly two taps are closed
    AST_DUAL_TAP: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> ($countones(tap_en) == 2));  // R3
    // R8: the wiper is never left floating
    AST_NEVER_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        tap_en != '0);  // R8
    // R8: a tap opens only as an overlap ends
    AST_BREAK_AFTER_MAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (|($past(tap_en) & ~tap_en)) |-> ($past(busy) && !busy));  // R8
    // R8: no tap closes in the cycle another opens
    AST_NO_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
        (|($past(tap_en) & ~tap_en)) |-> ((tap_en & ~$past(tap_en)) == '0));  // R8
endmodule

// File: tb/mbb_wiper_tap_decoder_test.sv
module mbb_wiper_tap_decoder_test;
    localparam int CODE_W = 7;
    localparam int TAPS   = 128;
    localparam int OVL    = 2;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [6:0]      code_in = 7'd64;
    logic [TAPS-1:0] tap_en;
    logic            busy;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    mbb_wiper_tap_decoder #(
        .CODE_W      (CODE_W),
        .OVERLAP_CYC (OVL),
        .RESET_CODE  (64)
    ) uut (
        .clk     (clk),
        .rst_n   (rst_n),
        .code_in (code_in),
        .tap_en  (tap_en),
        .busy    (busy)
    );

    function automatic logic [TAPS-1:0] bit_at(input int k);
        logic [TAPS-1:0] v = '0;
        v[k] = 1'b1;
        return v;
    endfunction

    task automatic check(input string req, input logic [TAPS-1:0] exp_en, input logic exp_busy);
        n_checks++;
        if (tap_en !== exp_en || busy !== exp_busy) begin
            n_fail++;
            $display("FAIL %s: tap_en=%h busy=%b expected tap_en=%h busy=%b",
                     req, tap_en, busy, exp_en, exp_busy);
        end
    endtask

    // Drive a new code at a falling edge, then check the overlap and the settled state.
    task automatic move(input string req, input int from_c, input int to_c);
        code_in = 7'(to_c);
        for (int i = 0; i < OVL; i++) begin
            @(negedge clk);
            check(req, bit_at(from_c) | bit_at(to_c), 1'b1);
        end
        @(negedge clk);
        check(req, bit_at(to_c), 1'b0);
    endtask

    task automatic test_reset();
        check("R1 in reset", bit_at(64), 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after reset", bit_at(64), 1'b0);
    endtask

    task automatic test_steady_moves();
        move("R3/R4 up 64->100", 64, 100);
        move("R3/R4 down 100->3", 100, 3);
        move("R2 step 3->4", 3, 4);
        @(negedge clk);
        check("R2 steady hold", bit_at(4), 1'b0);
    endtask

    task automatic test_no_change();
        code_in = 7'd4;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check("R5 same code", bit_at(4), 1'b0);
        end
    endtask

    task automatic test_extremes();
        move("R7 to 0", 4, 0);
        move("R7 0->127", 0, 127);
        move("R7 127->0", 127, 0);
        move("R7 0->64", 0, 64);
    endtask

    task automatic test_change_in_overlap();
        code_in = 7'd10;
        @(negedge clk);
        check("R6 first overlap", bit_at(64) | bit_at(10), 1'b1);
        code_in = 7'd90;
        for (int i = 1; i < OVL; i++) begin
            @(negedge clk);
            check("R6 overlap unchanged", bit_at(64) | bit_at(10), 1'b1);
        end
        @(negedge clk);
        check("R6 settle on 10", bit_at(10), 1'b0);
        for (int i = 0; i < OVL; i++) begin
            @(negedge clk);
            check("R6 second overlap", bit_at(10) | bit_at(90), 1'b1);
        end
        @(negedge clk);
        check("R6 reach 90", bit_at(90), 1'b0);
    endtask

    task automatic test_return_in_overlap();
        code_in = 7'd91;
        @(negedge clk);
        check("R6 return overlap", bit_at(90) | bit_at(91), 1'b1);
        code_in = 7'd90;
        for (int i = 1; i < OVL; i++) begin
            @(negedge clk);
            check("R6 return overlap held", bit_at(90) | bit_at(91), 1'b1);
        end
        @(negedge clk);
        check("R6 settle on 91", bit_at(91), 1'b0);
        for (int i = 0; i < OVL; i++) begin
            @(negedge clk);
            check("R6 move back", bit_at(91) | bit_at(90), 1'b1);
        end
        @(negedge clk);
        check("R6 back at 90", bit_at(90), 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        test_reset();
        test_steady_moves();
        test_no_change();
        test_extremes();
        test_change_in_overlap();
        test_return_in_overlap();
        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not complete");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule